// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter with Flags

This unit shifts an 8-, 16- or 32-bit operand by a variable count in one of three ways: a logical left shift, a logical right shift, or an arithmetic right shift. It also produces new carry, overflow, sign, zero and parity flags. An execution pipeline presents the operand, a width select, a 3-bit operation code, the count and the current flag values. On a valid strobe, the unit registers the shifted result, the new flags and a one-cycle flag-write enable.

The count is cut to its low five bits. A count that is zero after this cut, or an operation code outside the three shift codes, leaves the operand and flags unchanged and raises no flag write. Overflow has a defined value only for a single-bit shift. For every other count the unit drives it to 0.

Top module: `shift_flag_unit`

## Requirements
- R1: While rst_ni is low, result_o, every flag output and flag_we_o are 0.
- R2: op_i = 4 selects the logical left shift, 5 the logical right shift and 7 the arithmetic right shift. Any other code returns the width-masked operand with the input flags unchanged and flag_we_o low.
- R3: Only cnt_i[4:0] is used. Bits above bit 4 of the count have no effect.
- R4: Left shift: zeros enter at bit 0, and cf_o is the last bit shifted out past the top bit of the selected width.
- R5: Right shifts: cf_o is the last bit shifted out of bit 0. The logical form fills with zeros. The arithmetic form copies the sign bit, so it rounds toward negative infinity.
- R6: With an effective count of 1, of_o is result-top XOR cf_o for the left shift, 0 for the arithmetic right shift, and the operand's original top bit for the logical right shift.
- R7: With an effective count from 2 to 31, of_o is 0.
- R8: With an effective count of 0, the result equals the width-masked operand, all five flags pass through from their inputs, and flag_we_o stays low.
- R9: sf_o is the result's top bit at the selected width. zf_o is 1 when the result is zero at that width. pf_o is 1 when result bits 7:0 hold an even number of ones.
- R10: size_i = 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the selected width are 0.
- R11: A count greater than the width gives 0 for the logical shifts and all sign bits for the arithmetic shift. cf_o is then 0 for the logical shifts and the sign bit for the arithmetic shift. A count equal to the width leaves the last real bit in cf_o.
- R12: Outputs are loaded on the clock edge that samples valid_i high and hold otherwise. flag_we_o is high for exactly the cycle after a valid shift with a nonzero count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load strobe for the result and flag registers |
| op_i | input | 3 | Operation code: 4 left, 5 logical right, 7 arithmetic right |
| size_i | input | 2 | Operand width: 0 = 8, 1 = 16, 2/3 = 32 |
| cnt_i | input | CNT_W | Shift count; only the low 5 bits are used |
| operand_i | input | DATA_W | Operand |
| cf_i | input | 1 | Incoming carry flag |
| of_i | input | 1 | Incoming overflow flag |
| sf_i | input | 1 | Incoming sign flag |
| zf_i | input | 1 | Incoming zero flag |
| pf_i | input | 1 | Incoming parity flag |
| result_o | output | DATA_W | Registered shifted result |
| cf_o | output | 1 | Registered carry |
| of_o | output | 1 | Registered overflow |
| sf_o | output | 1 | Registered sign |
| zf_o | output | 1 | Registered zero |
| pf_o | output | 1 | Registered parity |
| flag_we_o | output | 1 | Flag-write enable, one cycle per effective shift |

## Verification
The bench uses the default parameters: DATA_W = 32, which builds all three width cores, and CNT_W = 8. With an 8-bit count, the bench can set count bits 5 to 7 and show they are ignored. The 32-bit width also lets counts run past the 8- and 16-bit operand widths, and lets the bench check that the bits above a narrow width stay clear. A bit-serial reference model in the bench sets the expected values for the directed cases and for a pseudo-random sweep.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  localparam logic [2:0] OP_SHL = 3'd4;
  localparam logic [2:0] OP_SHR = 3'd5;
  localparam logic [2:0] OP_SAR = 3'd7;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic pf;
  } flags_t;
endpackage

// File: rtl/shift_core.sv
// One operand width: computes shifted value and last bit out (count >= 1).
module shift_core
  import shift_unit_pkg::*;
#(
  parameter int W      = 8,
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [2:0]        op_i,
  input  logic [SH_W-1:0]   cnt_i,
  input  logic [W-1:0]      opnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  logic [W:0] left_w;
  logic [W:0] guard_w;
  logic [W:0] right_w;
  logic       fill;

  assign left_w  = {1'b0, opnd_i} << cnt_i;
  assign guard_w = {opnd_i, 1'b0};
  assign fill    = (op_i == OP_SAR) & opnd_i[W-1];
  // invert-shift-invert gives a sign fill without a wider datapath
  assign right_w = fill ? ~((~guard_w) >> cnt_i) : (guard_w >> cnt_i);

  always_comb begin
    if (op_i == OP_SHL) begin
      res_o = DATA_W'(left_w[W-1:0]);
      cy_o  = left_w[W];
    end else begin
      res_o = DATA_W'(right_w[W:1]);
      cy_o  = right_w[0];
    end
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [1:0]        size_idx_i,
  input  logic [2:0]        op_i,
  input  logic [SH_W-1:0]   cnt_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              src_top_i,
  input  logic              cy_i,
  output flags_t            flags_o
);
  logic res_top;
  logic ovf;

  always_comb begin
    case (size_idx_i)
      2'd0:    res_top = res_i[7];
      2'd1:    res_top = res_i[15];
      default: res_top = res_i[DATA_W-1];
    endcase
  end

  always_comb begin
    ovf = 1'b0;
    if (cnt_i == SH_W'(1)) begin
      case (op_i)
        OP_SHL:  ovf = res_top ^ cy_i;
        OP_SHR:  ovf = src_top_i;
        default: ovf = 1'b0;
      endcase
    end
  end

  assign flags_o.cf = cy_i;
  assign flags_o.of = ovf;
  assign flags_o.sf = res_top;
  assign flags_o.zf = (res_i == '0);
  assign flags_o.pf = ~^res_i[7:0];
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              cf_i,
  input  logic              of_i,
  input  logic              sf_i,
  input  logic              zf_i,
  input  logic              pf_i,
  output logic [DATA_W-1:0] result_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              pf_o,
  output logic              flag_we_o
);
  localparam int SH_W      = $clog2(DATA_W);
  localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1;
  localparam logic [1:0] MAX_IDX = 2'(NUM_SIZES - 1);

  logic [SH_W-1:0]   cnt_eff;
  logic              unused_cnt;
  logic              op_ok;
  logic              active;
  logic [1:0]        sz_idx;
  logic [DATA_W-1:0] res_s  [NUM_SIZES];
  logic [DATA_W-1:0] opnd_s [NUM_SIZES];
  logic              cy_s   [NUM_SIZES];
  logic              top_s  [NUM_SIZES];
  flags_t            calc_flags;
  flags_t            in_flags;
  flags_t            flags_q;
  logic [DATA_W-1:0] result_q;
  logic              we_q;

  assign cnt_eff    = cnt_i[SH_W-1:0];
  assign unused_cnt = ^cnt_i;
  assign op_ok      = (op_i == OP_SHL) || (op_i == OP_SHR) || (op_i == OP_SAR);
  assign active     = op_ok && (cnt_eff != '0);
  assign sz_idx     = (size_i >= MAX_IDX) ? MAX_IDX : size_i;
  assign in_flags   = '{cf: cf_i, of: of_i, sf: sf_i, zf: zf_i, pf: pf_i};

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int W = 8 << g;
    shift_core #(.W(W), .DATA_W(DATA_W), .SH_W(SH_W)) u_core (
      .op_i   (op_i),
      .cnt_i  (cnt_eff),
      .opnd_i (operand_i[W-1:0]),
      .res_o  (res_s[g]),
      .cy_o   (cy_s[g])
    );
    assign opnd_s[g] = DATA_W'(operand_i[W-1:0]);
    assign top_s[g]  = operand_i[W-1];
  end

  flag_gen #(.DATA_W(DATA_W), .SH_W(SH_W)) u_flags (
    .size_idx_i (sz_idx),
    .op_i       (op_i),
    .cnt_i      (cnt_eff),
    .res_i      (res_s[sz_idx]),
    .src_top_i  (top_s[sz_idx]),
    .cy_i       (cy_s[sz_idx]),
    .flags_o    (calc_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      flags_q  <= '0;
      we_q     <= 1'b0;
    end else begin
      we_q <= valid_i && active;
      if (valid_i) begin
        result_q <= active ? res_s[sz_idx] : opnd_s[sz_idx];
        flags_q  <= active ? calc_flags : in_flags;
      end
    end
  end

  assign result_o  = result_q;
  assign cf_o      = flags_q.cf;
  assign of_o      = flags_q.of;
  assign sf_o      = flags_q.sf;
  assign zf_o      = flags_q.zf;
  assign pf_o      = flags_q.pf;
  assign flag_we_o = we_q;

  AST_WE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !flag_we_o); // R12
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(cf_o)); // R12
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (cnt_i[SH_W-1:0] == '0) |=>
      !flag_we_o && (cf_o == $past(cf_i)) && (of_o == $past(of_i))); // R8
  AST_MULTI_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_ok && (cnt_i[SH_W-1:0] > SH_W'(1)) |=> !of_o); // R7
  AST_SAR_ONE_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_SAR) && (cnt_i[SH_W-1:0] == SH_W'(1)) |=> !of_o); // R6
  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (size_i == 2'd0) |=> (result_o[DATA_W-1:8] == '0)); // R10
  AST_BAD_OP_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_ok |=> !flag_we_o); // R2
endmodule

// File: tb/shift_flag_unit_bench.sv
module shift_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'd4;
  logic [1:0]  size = 2'd0;
  logic [7:0]  cnt = 8'd0;
  logic [31:0] opnd = 32'd0;
  logic [4:0]  fin = 5'd0;
  logic [31:0] res;
  logic        cf, of, sf, zf, pf, we;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  shift_flag_unit u_shift_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .cnt_i(cnt), .operand_i(opnd),
    .cf_i(fin[4]), .of_i(fin[3]), .sf_i(fin[2]), .zf_i(fin[1]), .pf_i(fin[0]),
    .result_o(res), .cf_o(cf), .of_o(of), .sf_o(sf), .zf_o(zf), .pf_o(pf),
    .flag_we_o(we)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // bit-serial reference: one position per step
  task automatic model(input logic [2:0] m_op, input logic [1:0] m_sz,
                       input logic [7:0] m_cnt, input logic [31:0] a,
                       input logic [4:0] f_in, output logic [31:0] r,
                       output logic [4:0] f, output logic w_en);
    int w = (m_sz == 2'd0) ? 8 : (m_sz == 2'd1) ? 16 : 32;
    logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    int c = int'(m_cnt) % 32;
    logic cy = 1'b0;
    logic ov = 1'b0;
    logic s;
    bit ok = (m_op == 3'd4) || (m_op == 3'd5) || (m_op == 3'd7);
    r = a & m;
    if (!ok || c == 0) begin
      f = f_in;
      w_en = 1'b0;
      return;
    end
    for (int k = 0; k < c; k++) begin
      if (m_op == 3'd4) begin
        cy = r[w-1];
        r = (r << 1) & m;
      end else begin
        cy = r[0];
        s = (m_op == 3'd7) ? r[w-1] : 1'b0;
        r = r >> 1;
        if (s) r[w-1] = 1'b1;
      end
    end
    if (c == 1) ov = (m_op == 3'd4) ? (r[w-1] ^ cy) : (m_op == 3'd7) ? 1'b0 : a[w-1];
    f = {cy, ov, r[w-1], (r == 32'd0), ~^r[7:0]};
    w_en = 1'b1;
  endtask

  task automatic run(string tag, logic [2:0] o, logic [1:0] s, logic [7:0] c,
                     logic [31:0] a, logic [4:0] f_in);
    logic [31:0] er;
    logic [4:0]  ef;
    logic        ew;
    @(negedge clk);
    op = o; size = s; cnt = c; opnd = a; fin = f_in; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    model(o, s, c, a, f_in, er, ef, ew);
    chk({tag, " result"}, res, er);
    chk({tag, " flags"}, {27'd0, cf, of, sf, zf, pf}, {27'd0, ef});
    chk({tag, " we"}, {31'd0, we}, {31'd0, ew});
  endtask

  task automatic t_reset;
    chk("R1 reset result", res, 32'd0);
    chk("R1 reset flags", {26'd0, cf, of, sf, zf, pf, we}, 32'd0);
  endtask

  task automatic t_left;
    run("R4 shl8", 3'd4, 2'd0, 8'd1, 32'h0000_0081, 5'd0);
    chk("R4 shl8 literal", res, 32'h0000_0002);
    chk("R6 shl8 of", {31'd0, of}, 32'd1);
    run("R4 shl16", 3'd4, 2'd1, 8'd4, 32'h0000_F00F, 5'd0);
    run("R4 shl32", 3'd4, 2'd2, 8'd31, 32'h0000_0003, 5'd0);
    chk("R4 shl32 literal", res, 32'h8000_0000);
  endtask

  task automatic t_right;
    run("R5 shr8", 3'd5, 2'd0, 8'd3, 32'h0000_00F5, 5'd0);
    chk("R5 shr8 literal", res, 32'h0000_001E);
    run("R5 sar8", 3'd7, 2'd0, 8'd3, 32'h0000_00F5, 5'd0);
    chk("R5 sar8 literal", res, 32'h0000_00FE);
    run("R5 sar32", 3'd7, 2'd3, 8'd1, 32'hFFFF_FFFF, 5'd0);
    chk("R5 sar rounds down", res, 32'hFFFF_FFFF);
    run("R5 shr16", 3'd5, 2'd1, 8'd9, 32'h0000_8001, 5'd0);
  endtask

  task automatic t_overflow;
    run("R6 shl one", 3'd4, 2'd1, 8'd1, 32'h0000_4000, 5'd0);
    run("R6 shr one", 3'd5, 2'd2, 8'd1, 32'h8000_0000, 5'd0);
    chk("R6 shr of top", {31'd0, of}, 32'd1);
    run("R6 sar one", 3'd7, 2'd0, 8'd1, 32'h0000_0080, 5'd0);
    run("R7 shl two", 3'd4, 2'd0, 8'd2, 32'h0000_0040, 5'd0);
    chk("R7 of zero", {31'd0, of}, 32'd0);
  endtask

  task automatic t_count_mask;
    run("R3 cnt 0x23", 3'd4, 2'd2, 8'h23, 32'h0000_0001, 5'd0);
    chk("R3 literal", res, 32'h0000_0008);
    run("R3 cnt 0xE0", 3'd5, 2'd2, 8'hE0, 32'h1234_5678, 5'b10101);
  endtask

  task automatic t_zero_count;
    run("R8 zero cnt", 3'd7, 2'd1, 8'd0, 32'hABCD_8765, 5'b11010);
    chk("R8 literal", res, 32'h0000_8765);
    chk("R8 we low", {31'd0, we}, 32'd0);
  endtask

  task automatic t_flags;
    run("R9 zero", 3'd5, 2'd0, 8'd8, 32'h0000_00FF, 5'd0);
    chk("R9 zf", {31'd0, zf}, 32'd1);
    run("R9 parity", 3'd4, 2'd1, 8'd1, 32'h0000_4003, 5'd0);
  endtask

  task automatic t_size;
    run("R10 size8 upper", 3'd4, 2'd0, 8'd4, 32'hFFFF_FFFF, 5'd0);
    chk("R10 literal", res, 32'h0000_00F0);
    run("R10 size16 upper", 3'd7, 2'd1, 8'd2, 32'hFFFF_8000, 5'd0);
    chk("R10 literal16", res, 32'h0000_E000);
  endtask

  task automatic t_beyond;
    run("R11 shl past", 3'd4, 2'd0, 8'd20, 32'h0000_00FF, 5'd0);
    run("R11 shr past", 3'd5, 2'd0, 8'd20, 32'h0000_00FF, 5'd0);
    run("R11 sar past", 3'd7, 2'd0, 8'd20, 32'h0000_0080, 5'd0);
    chk("R11 sar fill", res, 32'h0000_00FF);
    chk("R11 sar carry", {31'd0, cf}, 32'd1);
    run("R11 shr at width", 3'd5, 2'd1, 8'd16, 32'h0000_8000, 5'd0);
    chk("R11 at width carry", {31'd0, cf}, 32'd1);
  endtask

  task automatic t_bad_op;
    run("R2 op 6", 3'd6, 2'd0, 8'd3, 32'h0000_1234, 5'b01101);
    chk("R2 literal", res, 32'h0000_0034);
    run("R2 op 0", 3'd0, 2'd2, 8'd1, 32'h8000_0001, 5'b10010);
  endtask

  task automatic t_hold;
    logic [31:0] keep;
    run("R12 load", 3'd4, 2'd2, 8'd5, 32'h0F0F_0F0F, 5'd0);
    chk("R12 we pulse", {31'd0, we}, 32'd1);
    keep = res;
    opnd = 32'hDEAD_BEEF; cnt = 8'd7;
    @(negedge clk);
    chk("R12 hold result", res, keep);
    chk("R12 we drop", {31'd0, we}, 32'd0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] o = (i % 3 == 0) ? 3'd4 : (i % 3 == 1) ? 3'd5 : 3'd7;
      run("R4 R5 sweep", o, 2'($urandom % 4), 8'($urandom), $urandom, 5'($urandom));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_left;
    t_right;
    t_overflow;
    t_count_mask;
    t_zero_count;
    t_flags;
    t_size;
    t_beyond;
    t_bad_op;
    t_hold;
    t_sweep;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule